// File: doc/BRIEF.md
# Logic Analyzer Capture Packer

This block turns a 14-line digital probe bus into a stream of fixed-size memory bursts for a logic analyzer. A sampling controller takes one snapshot of the probe lines per tick. The tick comes either on every clock or once every `idleCycles + 1` clocks. Each snapshot becomes a 16-bit word, and sixteen of them are gathered into a 256-bit chunk. The packer hands each finished chunk to a writer stage in one cycle, together with a running byte count.

The writer offers each chunk on a valid/ready port as a single 32-byte burst. The burst address walks through a circular buffer given by a base and a size. Every time the written bytes fill one segment, the writer pulses an interrupt to the host. Two sticky flags watch integrity:
- **Overflow** is set when successive accepted chunks show a byte-count jump of more than one chunk, which means a chunk was dropped.
- **Underflow** is set when the number of segment notifications runs too far ahead of the count the host has acknowledged.

A capture either stops by itself after a programmed number of samples, or runs continuously and overwrites the buffer until it is stopped.

Top module: `capPacker`

## Requirements
- R1: Bit i of every sample word holds probe line i (i = 0..13). Bits 15:14 of every sample word are always 0.
- R2: While `hiChanEn` is 0, bits 13:12 of every sample word are forced to 0. While it is 1, they follow probe lines 12 and 13.
- R3: A chunk holds 16 samples. Sample k sits in `wrData[16k+15:16k]`, with the oldest sample at k = 0. The samples continue without gaps from one chunk to the next.
- R4: Consecutive samples are taken exactly `idleCycles + 1` clocks apart.
- R5: The byte counter advances by 32 for every completed chunk, including chunks that are dropped. `wrByteCnt` carries the counter value for the chunk being offered. After a `start` pulse, the first chunk carries 32.
- R6: The burst address of the k-th accepted chunk after `start` is `bufBase + (32k mod bufSize)`. `bufBase`, `bufSize` and `segSize` must be multiples of 32, and every burst address is 32-byte aligned.
- R7: Once `wrValid` is high, it stays high with `wrAddr` and `wrData` unchanged until `wrReady` is seen. A chunk that completes while a burst is still unaccepted is dropped.
- R8: When an accepted chunk carries a byte count more than 32 above the previous accepted chunk, the sticky `overflow` flag is set. Only `clearErr` clears it.
- R9: `segIrq` pulses for exactly one cycle each time the bytes accepted since `start` complete another `segSize` bytes.
- R10: On each segment notification, the notification count since `start` is compared with `hostAckCnt`. If it exceeds `hostAckCnt` by more than `pendLimit`, the sticky `underflow` flag is set. Only `clearErr` clears it.
- R11: With `contMode` at 0, capture ends after `sampleLimit` samples and `capturing` falls. With `contMode` at 1, capture runs until `stopReq`. In both cases a partly filled chunk is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and write clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse: begin a capture and clear the counters and the write pointer |
| stopReq | input | 1 | Pulse: end the capture |
| contMode | input | 1 | 1 = continuous wrap-around capture, 0 = one-shot capture |
| hiChanEn | input | 1 | Enables probe lines 12 and 13 |
| idleCycles | input | 8 | Idle clocks inserted between samples |
| sampleLimit | input | 32 | Number of samples in a one-shot capture (a multiple of 16) |
| chanIn | input | 14 | Probe lines |
| bufBase | input | 32 | Byte address of the start of the circular buffer |
| bufSize | input | 32 | Buffer size in bytes |
| segSize | input | 32 | Segment size in bytes |
| pendLimit | input | 16 | Allowed number of unacknowledged notifications |
| hostAckCnt | input | 16 | Number of notifications the host has consumed |
| clearErr | input | 1 | Clears `overflow` and `underflow` |
| wrReady | input | 1 | Memory writer accepts the offered burst |
| wrValid | output | 1 | A burst is offered |
| wrAddr | output | 32 | Burst byte address |
| wrData | output | 256 | Sixteen packed sample words |
| wrByteCnt | output | 32 | Byte counter value sent with the burst |
| segIrq | output | 1 | One-cycle segment-full interrupt |
| overflow | output | 1 | Sticky flag: a chunk was dropped |
| underflow | output | 1 | Sticky flag: the host fell behind |
| capturing | output | 1 | Capture in progress |

## Verification
A miscounted sample slot or a wrong divider state shows at the ports on the very next accepted burst: the spacing between neighbouring sample words breaks, or continuity with the previous chunk breaks. A wrong write offset or byte counter shows up as a wrong `wrAddr` or `wrByteCnt` on the first burst after the fault, and the wrap point exposes an off-by-one within one trip around the buffer. Faults in the segment and notification counters surface one segment later, as a missing or extra `segIrq` or as a sticky flag set in a run that keeps pace. A wrong overflow comparison only becomes visible once the writer stalls long enough to drop a chunk.

// File: rtl/capPkg.sv
package capPkg;
  // Strobes sent from the sampling control to the packing datapath
  typedef struct packed {
    logic tick;     // take a sample this cycle
    logic restart;  // clear slot and byte counter
  } capStrobe_t;
endpackage

// File: rtl/capSampler.sv
module capSampler
  import capPkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LIM_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             stopReq,
  input  logic             contMode,
  input  logic [DIV_W-1:0] idleCycles,
  input  logic [LIM_W-1:0] sampleLimit,
  output capStrobe_t       strobe,
  output logic             capturing
);
  logic             run;
  logic [DIV_W-1:0] divCnt;
  logic [LIM_W-1:0] taken;
  logic             tick;

  assign tick = run && (divCnt == '0);
  assign strobe.tick = tick;
  assign strobe.restart = start;
  assign capturing = run;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run    <= 1'b0;
      divCnt <= '0;
      taken  <= '0;
    end else if (start) begin
      run    <= 1'b1;
      divCnt <= '0;
      taken  <= '0;
    end else if (run) begin
      if (tick) begin
        taken  <= taken + LIM_W'(1);
        divCnt <= idleCycles;
        if (!contMode && ((taken + LIM_W'(1)) >= sampleLimit)) run <= 1'b0;
      end else begin
        divCnt <= divCnt - DIV_W'(1);
      end
      if (stopReq) run <= 1'b0;
    end
  end
endmodule

// File: rtl/capDatapath.sv
module capDatapath
  import capPkg::*;
#(
  parameter int CHANS     = 14,
  parameter int SAMP_W    = 16,
  parameter int PER_CHUNK = 16,
  parameter int CNT_W     = 32,
  localparam int CHUNK_W  = SAMP_W * PER_CHUNK,
  localparam int SLOT_W   = $clog2(PER_CHUNK)
) (
  input  logic               clk,
  input  logic               rstN,
  input  capStrobe_t         strobe,
  input  logic               hiChanEn,
  input  logic [CHANS-1:0]   chanIn,
  output logic               chunkValid,
  output logic [CHUNK_W-1:0] chunkData,
  output logic [CNT_W-1:0]   chunkCnt
);
  localparam int LOW_CH      = CHANS - 2;
  localparam int CHUNK_BYTES = CHUNK_W / 8;

  logic [SAMP_W-1:0]  word;
  logic [CHUNK_W-1:0] chunkReg;
  logic [SLOT_W-1:0]  slot;
  logic [CNT_W-1:0]   byteCnt;

  always_comb begin
    word = '0;
    word[LOW_CH-1:0] = chanIn[LOW_CH-1:0];
    if (hiChanEn) word[CHANS-1:LOW_CH] = chanIn[CHANS-1:LOW_CH];
  end

  assign chunkCnt = byteCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chunkReg   <= '0;
      slot       <= '0;
      byteCnt    <= '0;
      chunkValid <= 1'b0;
      chunkData  <= '0;
    end else begin
      chunkValid <= 1'b0;
      if (strobe.restart) begin
        slot    <= '0;
        byteCnt <= '0;
      end else if (strobe.tick) begin
        chunkReg[slot*SAMP_W +: SAMP_W] <= word;
        if (slot == SLOT_W'(PER_CHUNK - 1)) begin
          slot       <= '0;
          chunkValid <= 1'b1;
          chunkData  <= {word, chunkReg[CHUNK_W-SAMP_W-1:0]};
          byteCnt    <= byteCnt + CNT_W'(CHUNK_BYTES);
        end else begin
          slot <= slot + SLOT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/capWriter.sv
module capWriter #(
  parameter int CHUNK_W = 256,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 32,
  parameter int NOT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               restart,
  input  logic               chunkValid,
  input  logic [CHUNK_W-1:0] chunkData,
  input  logic [CNT_W-1:0]   chunkCnt,
  input  logic [ADDR_W-1:0]  bufBase,
  input  logic [ADDR_W-1:0]  bufSize,
  input  logic [ADDR_W-1:0]  segSize,
  input  logic [NOT_W-1:0]   pendLimit,
  input  logic [NOT_W-1:0]   hostAckCnt,
  input  logic               clearErr,
  input  logic               wrReady,
  output logic               wrValid,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [CHUNK_W-1:0] wrData,
  output logic [CNT_W-1:0]   wrByteCnt,
  output logic               segIrq,
  output logic               overflow,
  output logic               underflow
);
  localparam int BURST = CHUNK_W / 8;

  logic [ADDR_W-1:0] offset, segOff, offNext, segNext;
  logic [CNT_W-1:0]  lastCnt, cntDelta;
  logic [NOT_W-1:0]  notifyCnt, pendNext;
  logic              fire, free;

  assign fire     = wrValid && wrReady;
  assign free     = !wrValid || wrReady;
  assign wrAddr   = bufBase + offset;
  assign offNext  = offset + ADDR_W'(BURST);
  assign segNext  = segOff + ADDR_W'(BURST);
  assign cntDelta = chunkCnt - lastCnt;
  assign pendNext = notifyCnt + NOT_W'(1) - hostAckCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrValid   <= 1'b0;
      wrData    <= '0;
      wrByteCnt <= '0;
      offset    <= '0;
      segOff    <= '0;
      lastCnt   <= '0;
      notifyCnt <= '0;
      segIrq    <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      segIrq <= 1'b0;
      if (restart) begin
        wrValid   <= 1'b0;
        offset    <= '0;
        segOff    <= '0;
        lastCnt   <= '0;
        notifyCnt <= '0;
      end else begin
        if (fire) begin
          offset <= (offNext >= bufSize) ? '0 : offNext;
          if (segNext >= segSize) begin
            segOff    <= '0;
            segIrq    <= 1'b1;
            notifyCnt <= notifyCnt + NOT_W'(1);
            if (pendNext > pendLimit) underflow <= 1'b1;
          end else begin
            segOff <= segNext;
          end
        end
        if (chunkValid && free) begin
          wrValid   <= 1'b1;
          wrData    <= chunkData;
          wrByteCnt <= chunkCnt;
          lastCnt   <= chunkCnt;
          if (cntDelta > CNT_W'(BURST)) overflow <= 1'b1;
        end else if (fire) begin
          wrValid <= 1'b0;
        end
      end
      if (clearErr) begin
        overflow  <= 1'b0;
        underflow <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/capPacker.sv
module capPacker
  import capPkg::*;
#(
  parameter int CHANS     = 14,
  parameter int SAMP_W    = 16,
  parameter int PER_CHUNK = 16,
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 32,
  parameter int DIV_W     = 8,
  parameter int LIM_W     = 32,
  parameter int NOT_W     = 16,
  localparam int CHUNK_W  = SAMP_W * PER_CHUNK
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               stopReq,
  input  logic               contMode,
  input  logic               hiChanEn,
  input  logic [DIV_W-1:0]   idleCycles,
  input  logic [LIM_W-1:0]   sampleLimit,
  input  logic [CHANS-1:0]   chanIn,
  input  logic [ADDR_W-1:0]  bufBase,
  input  logic [ADDR_W-1:0]  bufSize,
  input  logic [ADDR_W-1:0]  segSize,
  input  logic [NOT_W-1:0]   pendLimit,
  input  logic [NOT_W-1:0]   hostAckCnt,
  input  logic               clearErr,
  input  logic               wrReady,
  output logic               wrValid,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [CHUNK_W-1:0] wrData,
  output logic [CNT_W-1:0]   wrByteCnt,
  output logic               segIrq,
  output logic               overflow,
  output logic               underflow,
  output logic               capturing
);
  capStrobe_t         strobe;
  logic               chunkValid;
  logic [CHUNK_W-1:0] chunkData;
  logic [CNT_W-1:0]   chunkCnt;

  capSampler #(.DIV_W(DIV_W), .LIM_W(LIM_W)) u_sampler (
    .clk(clk), .rstN(rstN), .start(start), .stopReq(stopReq),
    .contMode(contMode), .idleCycles(idleCycles), .sampleLimit(sampleLimit),
    .strobe(strobe), .capturing(capturing)
  );

  capDatapath #(.CHANS(CHANS), .SAMP_W(SAMP_W), .PER_CHUNK(PER_CHUNK),
                .CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hiChanEn(hiChanEn),
    .chanIn(chanIn), .chunkValid(chunkValid), .chunkData(chunkData),
    .chunkCnt(chunkCnt)
  );

  capWriter #(.CHUNK_W(CHUNK_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
              .NOT_W(NOT_W)) u_writer (
    .clk(clk), .rstN(rstN), .restart(start), .chunkValid(chunkValid),
    .chunkData(chunkData), .chunkCnt(chunkCnt), .bufBase(bufBase),
    .bufSize(bufSize), .segSize(segSize), .pendLimit(pendLimit),
    .hostAckCnt(hostAckCnt), .clearErr(clearErr), .wrReady(wrReady),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .wrByteCnt(wrByteCnt), .segIrq(segIrq), .overflow(overflow),
    .underflow(underflow)
  );
endmodule

// File: rtl/capPackerChk.sv
module capPackerChk #(
  parameter int CHANS     = 14,
  parameter int SAMP_W    = 16,
  parameter int PER_CHUNK = 16,
  parameter int ADDR_W    = 32,
  localparam int CHUNK_W  = SAMP_W * PER_CHUNK
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               clearErr,
  input logic               wrValid,
  input logic               wrReady,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [CHUNK_W-1:0] wrData,
  input logic               segIrq,
  input logic               overflow,
  input logic               underflow
);
  function automatic logic spareBitsClear(input logic [CHUNK_W-1:0] d);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < PER_CHUNK; k++) begin
      if ((d[k*SAMP_W +: SAMP_W] >> CHANS) != '0) ok = 1'b0;
    end
    return ok;
  endfunction

  // R1
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> spareBitsClear(wrData));

  // R6
  addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrAddr[4:0] == 5'd0));

  // R7
  handshake_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady && !start) |=> (wrValid && $stable(wrAddr) && $stable(wrData)));

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !clearErr) |=> overflow);

  // R9
  seg_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    segIrq |=> !segIrq);

  // R10
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !clearErr) |=> underflow);
endmodule

bind capPacker capPackerChk #(
  .CHANS(CHANS), .SAMP_W(SAMP_W), .PER_CHUNK(PER_CHUNK), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .clearErr(clearErr),
  .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData),
  .segIrq(segIrq), .overflow(overflow), .underflow(underflow)
);

// File: tb/capPacker_tb.sv
module capPacker_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0, stopReq = 1'b0, contMode = 1'b1, hiChanEn = 1'b0;
  logic [7:0]   idleCycles = '0;
  logic [31:0]  sampleLimit = '0;
  logic [13:0]  chanIn = '0;
  logic [31:0]  bufBase = '0, bufSize = 32'd128, segSize = 32'd64;
  logic [15:0]  pendLimit = 16'd1, hostAckCnt;
  logic         clearErr = 1'b0, wrReady = 1'b1;
  logic         wrValid, segIrq, overflow, underflow, capturing;
  logic [31:0]  wrAddr, wrByteCnt;
  logic [255:0] wrData;

  int  errors = 0, checks = 0, cycles = 0;
  int  gotChunks = 0, irqSeen = 0;
  bit  hostKeeps = 1'b1, checkStream = 1'b1;
  logic [15:0] prevW;
  logic [255:0] snap;

  assign hostAckCnt = hostKeeps ? 16'(irqSeen) : 16'd0;

  capPacker u_dut (
    .clk(clk), .rstN(rstN), .start(start), .stopReq(stopReq),
    .contMode(contMode), .hiChanEn(hiChanEn), .idleCycles(idleCycles),
    .sampleLimit(sampleLimit), .chanIn(chanIn), .bufBase(bufBase),
    .bufSize(bufSize), .segSize(segSize), .pendLimit(pendLimit),
    .hostAckCnt(hostAckCnt), .clearErr(clearErr), .wrReady(wrReady),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .wrByteCnt(wrByteCnt), .segIrq(segIrq), .overflow(overflow),
    .underflow(underflow), .capturing(capturing)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // probe lines count up once per clock
  always @(posedge clk) begin
    #1 chanIn <= chanIn + 14'd1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] expAddr(input int k);
    return bufBase + ((k * 32) % bufSize);
  endfunction

  // monitor: a burst is taken at the next edge when valid and ready
  always @(negedge clk) begin
    if (rstN && segIrq) irqSeen++;
    if (rstN && wrValid && wrReady) begin
      if (checkStream) begin
        bit bad;
        logic [15:0] mask, w, dlt;
        bad = 1'b0;
        mask = hiChanEn ? 16'h3FFF : 16'h0FFF;
        check(wrAddr == expAddr(gotChunks), "R6", "burst address", wrAddr, expAddr(gotChunks));
        check(wrByteCnt == 32'(32 * (gotChunks + 1)), "R5", "byte counter",
              wrByteCnt, 32 * (gotChunks + 1));
        for (int s = 0; s < 16; s++) begin
          w = wrData[s*16 +: 16];
          if (w[15:14] != 2'b00) bad = 1'b1;               // R1
          if (!hiChanEn && w[13:12] != 2'b00) bad = 1'b1;  // R2
          if (s > 0 || gotChunks > 0) begin
            dlt = (w - prevW) & mask;                      // R3, R4
            if (dlt != 16'(idleCycles) + 16'd1) bad = 1'b1;
          end
          prevW = w;
        end
        check(!bad, "R3/R4 R1 R2", "sample words", 0, 0);
      end
      gotChunks++;
    end
  end

  task automatic startRun(input logic [31:0] base, input logic [31:0] size,
                          input logic [31:0] seg, input logic [7:0] idle,
                          input bit hi, input bit cont, input logic [31:0] lim);
    @(posedge clk); #1;
    bufBase = base; bufSize = size; segSize = seg; idleCycles = idle;
    hiChanEn = hi; contMode = cont; sampleLimit = lim;
    start = 1'b1;
    @(negedge clk); gotChunks = 0; irqSeen = 0;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic stopRun();
    @(posedge clk); #1 stopReq = 1'b1;
    @(posedge clk); #1 stopReq = 1'b0;
    repeat (40) @(posedge clk);
  endtask

  task automatic pulseClear();
    @(posedge clk); #1 clearErr = 1'b1;
    @(posedge clk); #1 clearErr = 1'b0;
    @(negedge clk);
  endtask

  task automatic contRun(input logic [31:0] base, input logic [31:0] size,
                         input logic [31:0] seg, input logic [7:0] idle,
                         input bit hi, input int n);
    int expIrq;
    startRun(base, size, seg, idle, hi, 1'b1, 32'd0);
    while (gotChunks < n) @(negedge clk);
    check(capturing == 1'b1, "R11", "capturing in continuous run", capturing, 1);
    stopRun();
    expIrq = (gotChunks * 32) / int'(seg);
    check(irqSeen == expIrq, "R9", "segment interrupts", irqSeen, expIrq);
    check(overflow == 1'b0, "R8", "no overflow at full rate", overflow, 0);
    check(underflow == 1'b0, "R10", "no underflow while host keeps up", underflow, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(wrValid == 1'b0 && overflow == 1'b0 && underflow == 1'b0 &&
          segIrq == 1'b0 && capturing == 1'b0, "R7", "reset state",
          {wrValid, overflow, underflow, segIrq, capturing}, 0);
    #1 rstN = 1'b1;
    repeat (2) @(posedge clk);

    // directed: full rate, wrap at 4 bursts, 2 bursts per segment
    contRun(32'h1000, 32'd128, 32'd64, 8'd0, 1'b0, 10);
    // directed: slowed rate, all 14 lines, wrap at 3 bursts
    contRun(32'h2000, 32'd96, 32'd32, 8'd3, 1'b1, 7);
    // random runs
    for (int r = 0; r < 4; r++) begin
      contRun(32'h4000 + 32'(32 * $urandom_range(0, 63)),
              32'(32 * $urandom_range(2, 6)), 32'(32 * $urandom_range(1, 3)),
              8'($urandom_range(0, 4)), 1'($urandom_range(0, 1)),
              int'($urandom_range(5, 12)));
    end

    // R11 one-shot: 80 samples = 5 chunks
    startRun(32'h3000, 32'd256, 32'd64, 8'd1, 1'b0, 1'b0, 32'd80);
    repeat (400) @(posedge clk);
    @(negedge clk);
    check(gotChunks == 5, "R11", "one-shot chunk count", gotChunks, 5);
    check(capturing == 1'b0, "R11", "one-shot ends capture", capturing, 0);

    // R7/R8 stalled writer drops chunks
    checkStream = 1'b0;
    @(posedge clk); #1 wrReady = 1'b0;
    startRun(32'h0, 32'd256, 32'd256, 8'd0, 1'b0, 1'b1, 32'd0);
    repeat (20) @(posedge clk);
    @(negedge clk); snap = wrData;
    check(wrValid == 1'b1, "R7", "burst offered while stalled", wrValid, 1);
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(wrValid == 1'b1 && wrData == snap, "R7", "stalled burst kept, newer dropped",
          wrData[31:0], snap[31:0]);
    check(overflow == 1'b0, "R8", "no flag before the gap is seen", overflow, 0);
    @(posedge clk); #1 wrReady = 1'b1;
    repeat (60) @(posedge clk);
    stopRun();
    check(overflow == 1'b1, "R8", "overflow after dropped chunks", overflow, 1);
    pulseClear();
    check(overflow == 1'b0, "R8", "clearErr clears overflow", overflow, 0);
    checkStream = 1'b1;

    // R10 host stops acknowledging
    hostKeeps = 1'b0; pendLimit = 16'd2;
    startRun(32'h0, 32'd512, 32'd32, 8'd0, 1'b0, 1'b1, 32'd0);
    while (irqSeen < 2) @(negedge clk);
    check(underflow == 1'b0, "R10", "two pending within limit", underflow, 0);
    while (irqSeen < 3) @(negedge clk);
    check(underflow == 1'b1, "R10", "third pending exceeds limit", underflow, 1);
    stopRun();
    pulseClear();
    check(underflow == 1'b0, "R10", "clearErr clears underflow", underflow, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule